// File: doc/BRIEF.md
# Calendar Clock Core

This block is a time-of-day and calendar counter of the kind kept alive by a backup battery on a PC board. A free-running enable, `tick`, pulses once per period of a 32768 Hz time base. A prescaler counts those pulses and advances the calendar once per second. Software reaches the clock through a small indexed register file: it presents an index on `addr` and reads `rd_data` combinationally, or it writes a byte with `wr_en`.

The time fields are seconds, minutes, hours, weekday, day of month, month and a two-digit year. They are held exactly as software wrote them, in BCD or in binary, and the once-per-second update increments them in whichever format is selected. Hours run either from 0 to 23, or from 1 to 12 with a PM flag in the top bit. Software can freeze the update while it loads a new time. It can also hold the prescaler in reset, so that the first tick after release lands half a second later. An update-in-progress flag warns readers shortly before the fields change and stays up a little while after. A power-status bit records whether supply has been lost since it was last read.

The prescaler is a state machine with three states. `ST_RUN` counts ticks. `ST_STOP` holds the count. `ST_PRESET` forces the count to its half-second start point. Every cycle the next state is chosen from the divider field: `111` gives `ST_PRESET`, `010` gives `ST_RUN`, and any other code gives `ST_STOP`. Any state can move to any other in this way.

Top module: `cal_clock_core`

## Requirements
- R1: The time fields are at these indices: seconds 0, minutes 2, hours 4, weekday 6 (1–7), day of month 7, month 8, year 9. Each reads back what was written. Indices other than 0, 2, 4, 6, 7, 8, 9, 10, 11 and 13 read as zero.
- R2: Bit 2 of index 11 selects the number format: 0 means BCD, 1 means binary. The update increments every field in that format, so in BCD 0x09 becomes 0x10, and in binary 9 becomes 0x0A.
- R3: Bit 1 of index 11 selects the hour format: 1 means 0–23, 0 means 1–12 with bit 7 of the hour byte set for PM. In 12-hour mode, 11 AM steps to 12 PM (BCD 0x11 to 0x92) and 11 PM steps to 12 AM (0x91 to 0x12).
- R4: Carries cascade from seconds at 59 through minutes at 59 and hours at 23. On a day carry, the weekday goes from 7 back to 1. The day of month wraps to 1 after the month's last day, and February has 29 days when the year is divisible by 4. The month goes from 12 to 1 and the year from 99 to 0.
- R5: Bit 7 of index 10 is a read-only update-in-progress flag. It is 1 for the last UIP_LEAD tick periods before an update and for UIP_HOLD tick periods after it. Writes to that bit are ignored.
- R6: While bit 7 of index 11 is 1, no update takes place. A second boundary that passes while frozen is dropped, not queued.
- R7: Bits 6:4 of index 10 drive the divider: 010 counts, 111 holds the prescaler in reset, and any other code stops it where it is.
- R8: When the divider goes from 111 to 010, the first update follows after TICKS_PER_SEC/2 ticks, and later updates come every TICKS_PER_SEC ticks.
- R9: Bit 7 of index 13 is 0 after reset or after a `pwr_fail` pulse. A read of index 13 with `rd_en` returns the current value and then sets the bit to 1.
- R10: Writes to time fields are accepted while the clock runs. The next update increments the value just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable per time-base period |
| addr | input | ADDR_W | Register index |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, used for the read side effect of index 13 |
| pwr_fail | input | 1 | Pulse marking a loss of supply |
| rd_data | output | 8 | Read data for `addr` (combinational) |

## Verification
The bench builds the block with TICKS_PER_SEC = 8, UIP_LEAD = 2 and UIP_HOLD = 1. At these values one second is eight ticks and the half-second restart is four, so every update, freeze window, stop interval and flag edge can be reached in a few cycles. That short second makes it affordable to sweep all 24 hours in all four format combinations, all 60 seconds in both number formats, and every month end across leap, non-leap and year-99 cases. Each sweep is checked against encodings that the bench computes arithmetically.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int IDX_SEC  = 0;
    localparam int IDX_MIN  = 2;
    localparam int IDX_HOUR = 4;
    localparam int IDX_WDAY = 6;
    localparam int IDX_MDAY = 7;
    localparam int IDX_MON  = 8;
    localparam int IDX_YEAR = 9;
    localparam int IDX_CTLA = 10;
    localparam int IDX_CTLB = 11;
    localparam int IDX_STAT = 13;

    localparam logic [2:0] DIV_RUN   = 3'b010;
    localparam logic [2:0] DIV_RESET = 3'b111;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] wday;
        logic [7:0] mday;
        logic [7:0] mon;
        logic [7:0] year;
    } cal_time_t;

    typedef enum logic [1:0] {ST_RUN, ST_STOP, ST_PRESET} div_state_e;

    function automatic logic [6:0] raw_to_val(input logic [7:0] raw, input logic bin);
        if (bin) return raw[6:0];
        return 7'({3'b000, raw[7:4]} * 7'd10 + {3'b000, raw[3:0]});
    endfunction

    function automatic logic [7:0] val_to_raw(input logic [6:0] v, input logic bin);
        if (bin) return {1'b0, v};
        return 8'(({1'b0, v / 7'd10} * 8'd16) + {1'b0, v % 7'd10});
    endfunction

    function automatic logic [6:0] hour_to_24(input logic [7:0] raw, input logic bin,
                                              input logic h24);
        logic [6:0] v;
        v = raw_to_val({1'b0, raw[6:0]}, bin);
        if (h24) return v;
        if (v == 7'd12) return raw[7] ? 7'd12 : 7'd0;
        return raw[7] ? 7'(v + 7'd12) : v;
    endfunction

    function automatic logic [7:0] hour_from_24(input logic [6:0] h, input logic bin,
                                                input logic h24);
        logic [6:0] h12;
        if (h24) return val_to_raw(h, bin);
        if (h == 7'd0)       h12 = 7'd12;
        else if (h > 7'd12)  h12 = 7'(h - 7'd12);
        else                 h12 = h;
        return {(h >= 7'd12), 7'b0} | val_to_raw(h12, bin);
    endfunction

    function automatic logic [6:0] days_in_month(input logic [6:0] mon, input logic [6:0] year);
        case (mon)
            7'd2:                         return (year[1:0] == 2'b00) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:      return 7'd30;
            default:                      return 7'd31;
        endcase
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler
    import cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_LEAD      = 8,
    parameter int UIP_HOLD      = 58
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [2:0] div,
    input  logic       freeze,
    output logic       upd,
    output logic       uip
);
    localparam int            CW       = $clog2(TICKS_PER_SEC);
    localparam logic [CW-1:0] LAST     = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] START    = CW'(TICKS_PER_SEC - TICKS_PER_SEC / 2);
    localparam logic [CW-1:0] LEAD_AT  = CW'(TICKS_PER_SEC - UIP_LEAD);
    localparam logic [CW-1:0] HOLD_END = CW'(UIP_HOLD);

    div_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        if (div == DIV_RESET)    state_d = ST_PRESET;
        else if (div == DIV_RUN) state_d = ST_RUN;
        else                     state_d = ST_STOP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= START;
        end else begin
            unique case (state_q)
                ST_PRESET: cnt_q <= START;
                ST_RUN:    if (tick) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                ST_STOP:   cnt_q <= cnt_q;
                default:   cnt_q <= START;
            endcase
        end
    end

    always_comb begin
        upd = (state_q == ST_RUN) && tick && (cnt_q == LAST) && !freeze;
        uip = (cnt_q >= LEAD_AT) || (cnt_q < HOLD_END);
    end

endmodule

// File: rtl/cal_advance.sv
module cal_advance
    import cal_pkg::*;
(
    input  cal_time_t cur,
    input  logic      bin,
    input  logic      h24,
    output cal_time_t nxt
);
    logic [6:0] s, m, h, wd, md, mo, y, dim_v;
    logic [6:0] s_n, m_n, h_n, wd_n, md_n, mo_n, y_n;
    logic       c_s, c_m, c_h, c_d, c_mo;

    always_comb begin
        s  = raw_to_val(cur.sec, bin);
        m  = raw_to_val(cur.min, bin);
        h  = hour_to_24(cur.hour, bin, h24);
        wd = raw_to_val(cur.wday, bin);
        md = raw_to_val(cur.mday, bin);
        mo = raw_to_val(cur.mon, bin);
        y  = raw_to_val(cur.year, bin);
        dim_v = days_in_month(mo, y);

        c_s  = (s >= 7'd59);
        c_m  = c_s && (m >= 7'd59);
        c_h  = c_m && (h >= 7'd23);
        c_d  = c_h && (md >= dim_v);
        c_mo = c_d && (mo >= 7'd12);

        s_n  = c_s  ? 7'd0 : 7'(s + 7'd1);
        m_n  = c_m  ? 7'd0 : 7'(m + 7'd1);
        h_n  = c_h  ? 7'd0 : 7'(h + 7'd1);
        wd_n = (wd >= 7'd7) ? 7'd1 : 7'(wd + 7'd1);
        md_n = c_d  ? 7'd1 : 7'(md + 7'd1);
        mo_n = c_mo ? 7'd1 : 7'(mo + 7'd1);
        y_n  = (y >= 7'd99) ? 7'd0 : 7'(y + 7'd1);

        nxt.sec  = val_to_raw(s_n, bin);
        nxt.min  = c_s  ? val_to_raw(m_n, bin)        : cur.min;
        nxt.hour = c_m  ? hour_from_24(h_n, bin, h24) : cur.hour;
        nxt.wday = c_h  ? val_to_raw(wd_n, bin)       : cur.wday;
        nxt.mday = c_h  ? val_to_raw(md_n, bin)       : cur.mday;
        nxt.mon  = c_d  ? val_to_raw(mo_n, bin)       : cur.mon;
        nxt.year = c_mo ? val_to_raw(y_n, bin)        : cur.year;
    end

endmodule

// File: rtl/cal_clock_core.sv
module cal_clock_core
    import cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_LEAD      = 8,
    parameter int UIP_HOLD      = 58,
    parameter int ADDR_W        = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic              pwr_fail,
    output logic [7:0]        rd_data
);
    cal_time_t  t_q, t_nxt;
    logic [2:0] div_q;
    logic       set_q, bin_q, h24_q, pwr_ok_q;
    logic       upd, uip;

    cal_prescaler #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .UIP_LEAD     (UIP_LEAD),
        .UIP_HOLD     (UIP_HOLD)
    ) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .div   (div_q),
        .freeze(set_q),
        .upd   (upd),
        .uip   (uip)
    );

    cal_advance u_adv (
        .cur(t_q),
        .bin(bin_q),
        .h24(h24_q),
        .nxt(t_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '{sec: 8'h00, min: 8'h00, hour: 8'h12, wday: 8'h01,
                     mday: 8'h01, mon: 8'h01, year: 8'h00};
        end else begin
            if (upd) t_q <= t_nxt;
            if (wr_en) begin
                case (addr)
                    ADDR_W'(IDX_SEC):  t_q.sec  <= wr_data;
                    ADDR_W'(IDX_MIN):  t_q.min  <= wr_data;
                    ADDR_W'(IDX_HOUR): t_q.hour <= wr_data;
                    ADDR_W'(IDX_WDAY): t_q.wday <= wr_data;
                    ADDR_W'(IDX_MDAY): t_q.mday <= wr_data;
                    ADDR_W'(IDX_MON):  t_q.mon  <= wr_data;
                    ADDR_W'(IDX_YEAR): t_q.year <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= DIV_RUN;
            set_q    <= 1'b0;
            bin_q    <= 1'b0;
            h24_q    <= 1'b0;
            pwr_ok_q <= 1'b0;
        end else begin
            if (wr_en && addr == ADDR_W'(IDX_CTLA)) div_q <= wr_data[6:4];
            if (wr_en && addr == ADDR_W'(IDX_CTLB)) begin
                set_q <= wr_data[7];
                bin_q <= wr_data[2];
                h24_q <= wr_data[1];
            end
            if (pwr_fail)                                  pwr_ok_q <= 1'b0;
            else if (rd_en && addr == ADDR_W'(IDX_STAT))   pwr_ok_q <= 1'b1;
        end
    end

    always_comb begin
        case (addr)
            ADDR_W'(IDX_SEC):  rd_data = t_q.sec;
            ADDR_W'(IDX_MIN):  rd_data = t_q.min;
            ADDR_W'(IDX_HOUR): rd_data = t_q.hour;
            ADDR_W'(IDX_WDAY): rd_data = t_q.wday;
            ADDR_W'(IDX_MDAY): rd_data = t_q.mday;
            ADDR_W'(IDX_MON):  rd_data = t_q.mon;
            ADDR_W'(IDX_YEAR): rd_data = t_q.year;
            ADDR_W'(IDX_CTLA): rd_data = {uip, div_q, 4'b0000};
            ADDR_W'(IDX_CTLB): rd_data = {set_q, 4'b0000, bin_q, h24_q, 1'b0};
            ADDR_W'(IDX_STAT): rd_data = {pwr_ok_q, 7'b0};
            default:           rd_data = 8'h00;
        endcase
    end

endmodule

// File: rtl/cal_clock_checker.sv
module cal_clock_checker #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd,
    input logic              uip,
    input logic              set_q,
    input logic              wr_en,
    input logic              rd_en,
    input logic              pwr_fail,
    input logic              pwr_ok_q,
    input logic [2:0]        div_q,
    input logic [7:0]        sec_q,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        rd_data
);
    logic mapped;
    always_comb mapped = addr inside {ADDR_W'(0), ADDR_W'(2), ADDR_W'(4), ADDR_W'(6),
                                      ADDR_W'(7), ADDR_W'(8), ADDR_W'(9), ADDR_W'(10),
                                      ADDR_W'(11), ADDR_W'(13)};

    p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (rd_data == 8'h00));

    p_uip_at_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> uip);

    p_uip_after_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> uip);

    p_frozen_sec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_q && !(wr_en && addr == ADDR_W'(0))) |=> (sec_q == $past(sec_q)));

    p_preset_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == 3'b111 && $past(div_q) == 3'b111) |-> !upd);

    p_status_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(13) && !pwr_fail) |=> pwr_ok_q);

    p_power_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> !pwr_ok_q);

endmodule

bind cal_clock_core cal_clock_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (upd),
    .uip     (uip),
    .set_q   (set_q),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .pwr_fail(pwr_fail),
    .pwr_ok_q(pwr_ok_q),
    .div_q   (div_q),
    .sec_q   (t_q.sec),
    .addr    (addr),
    .rd_data (rd_data)
);

// File: tb/sim_cal_clock_core.sv
module sim_cal_clock_core;
    localparam int TK = 8;
    localparam int LD = 2;
    localparam int HD = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [6:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic       pwr_fail = 1'b0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cal_clock_core #(.TICKS_PER_SEC(TK), .UIP_LEAD(LD), .UIP_HOLD(HD), .ADDR_W(7)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .pwr_fail(pwr_fail), .rd_data(rd_data)
    );

    function automatic int enc(int v, bit b);
        return b ? v : ((v / 10) * 16 + v % 10);
    endfunction

    function automatic int enc_hr(int h, bit b, bit h24);
        int h12;
        if (h24) return enc(h, b);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return ((h >= 12) ? 128 : 0) + enc(h12, b);
    endfunction

    function automatic int dim(int m, int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr = 7'(a); wr_data = 8'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        addr = 7'(a);
        #1 v = int'(rd_data);
    endtask

    task automatic rd_stat(output int v);
        @(negedge clk);
        addr = 7'd13; rd_en = 1'b1;
        #1 v = int'(rd_data);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic load(input bit b, input bit h24, input int s, input int mi, input int h,
                        input int wd, input int md, input int mo, input int y);
        int mode;
        mode = (b ? 4 : 0) + (h24 ? 2 : 0);
        wr(11, 128 + mode);
        wr(0, enc(s, b));   wr(2, enc(mi, b));  wr(4, enc_hr(h, b, h24));
        wr(6, enc(wd, b));  wr(7, enc(md, b));  wr(8, enc(mo, b));  wr(9, enc(y, b));
        wr(10, 'h70); wr(10, 'h20);
        wr(11, mode);
    endtask

    initial begin
        int v, v2, em, ey;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        rd(0, v);  chk("R1", "reset sec", v, 'h00);
        rd(4, v);  chk("R3", "reset hour 12AM", v, 'h12);
        rd(7, v);  chk("R1", "reset mday", v, 'h01);
        rd(10, v); chk("R7", "reset ctl A", v, 'h20);
        rd(11, v); chk("R2", "reset ctl B", v, 'h00);
        rd(13, v); chk("R9", "reset status", v, 'h00);
        rd(5, v);  chk("R1", "unused 5", v, 0);
        rd(127, v); chk("R1", "unused 127", v, 0);
        wr(5, 'hFF); rd(5, v); chk("R1", "unused 5 after write", v, 0);

        // R1 readback
        load(0, 1, 10, 20, 8, 3, 15, 6, 42);
        rd(2, v); chk("R1", "min readback", v, 'h20);
        rd(9, v); chk("R1", "year readback", v, 'h42);
        rd(6, v); chk("R1", "wday readback", v, 'h03);

        // R8 half-second start then full period
        ticks(TK / 2 - 1); rd(0, v); chk("R8", "no update before half", v, 'h10);
        ticks(1);          rd(0, v); chk("R8", "first update at half", v, 'h11);
        ticks(TK - 1);     rd(0, v); chk("R8", "no early second update", v, 'h11);
        ticks(1);          rd(0, v); chk("R8", "second update full period", v, 'h12);

        // R5 update-in-progress window
        load(0, 1, 30, 0, 0, 1, 1, 1, 0);
        wr(10, 'hA0); rd(10, v); chk("R5", "bit7 write ignored", v, 'h20);
        ticks(TK / 2 - LD - 1); rd(10, v); chk("R5", "uip low before lead", v & 'h80, 0);
        ticks(1); rd(10, v); rd(0, v2);
        chk("R5", "uip raised in lead", v & 'h80, 'h80);
        chk("R5", "fields stable in lead", v2, 'h30);
        ticks(LD - 1); rd(10, v); chk("R5", "uip high last lead tick", v & 'h80, 'h80);
        ticks(1); rd(10, v); rd(0, v2);
        chk("R5", "uip held after update", v & 'h80, 'h80);
        chk("R5", "updated", v2, 'h31);
        ticks(HD); rd(10, v); chk("R5", "uip low after hold", v & 'h80, 0);

        // R6 freeze drops updates
        load(0, 1, 40, 0, 0, 1, 1, 1, 0);
        wr(11, 'h82);
        ticks(2 * TK); rd(0, v); chk("R6", "frozen sec", v, 'h40);
        wr(11, 'h02);
        ticks(TK / 2 - 1); rd(0, v); chk("R6", "no queued update", v, 'h40);
        ticks(1); rd(0, v); chk("R6", "single resume update", v, 'h41);

        // R7 stop code and reset code
        load(0, 1, 50, 0, 0, 1, 1, 1, 0);
        ticks(TK / 2 - LD);
        wr(10, 'h00);
        ticks(3 * TK); rd(0, v); chk("R7", "stopped sec", v, 'h50);
        rd(10, v); chk("R7", "stopped keeps uip", v, 'h80);
        wr(10, 'h20);
        ticks(LD - 1); rd(0, v); chk("R7", "resume from held count", v, 'h50);
        ticks(1); rd(0, v); chk("R7", "resume update", v, 'h51);
        wr(10, 'h70);
        ticks(3 * TK); rd(0, v); chk("R7", "prescaler reset holds", v, 'h51);
        wr(10, 'h20);
        ticks(TK / 2); rd(0, v); chk("R8", "restart half second", v, 'h52);

        // R10 write while running
        load(0, 1, 5, 0, 0, 1, 1, 1, 0);
        ticks(2);
        wr(0, 'h30);
        ticks(TK / 2 - 2); rd(0, v); chk("R10", "write then increment", v, 'h31);

        // R9 power status
        rd_stat(v); chk("R9", "read returns lost", v, 'h00);
        rd(13, v);  chk("R9", "set after read", v, 'h80);
        @(negedge clk); pwr_fail = 1'b1; @(negedge clk); pwr_fail = 1'b0;
        rd(13, v);  chk("R9", "cleared by power loss", v, 'h00);

        // R2 seconds sweep in both formats
        for (int b = 0; b < 2; b++) begin
            for (int s = 0; s < 60; s++) begin
                load(b[0], 1, s, 0, 0, 1, 1, 1, 0);
                ticks(TK / 2);
                rd(0, v); chk("R2", "sec step", v, enc((s + 1) % 60, b[0]));
                rd(2, v); chk("R2", "min carry", v, enc((s == 59) ? 1 : 0, b[0]));
            end
        end

        // R3 hour sweep across formats
        for (int b = 0; b < 2; b++) begin
            for (int f = 0; f < 2; f++) begin
                for (int h = 0; h < 24; h++) begin
                    load(b[0], f[0], 59, 59, h, 3, 10, 5, 20);
                    ticks(TK / 2);
                    rd(4, v); chk("R3", "hour step", v, enc_hr((h + 1) % 24, b[0], f[0]));
                    rd(7, v); chk("R4", "day carry from hour", v, enc((h == 23) ? 11 : 10, b[0]));
                end
            end
        end

        // R4 month-end sweep
        for (int b = 0; b < 2; b++) begin
            for (int yi = 0; yi < 3; yi++) begin
                for (int m = 1; m <= 12; m++) begin
                    int y;
                    y = (yi == 0) ? 23 : (yi == 1) ? 24 : 99;
                    load(b[0], 1, 59, 59, 23, 7, dim(m, y), m, y);
                    ticks(TK / 2);
                    em = (m == 12) ? 1 : m + 1;
                    ey = (m == 12) ? (y + 1) % 100 : y;
                    rd(7, v); chk("R4", "mday wrap", v, enc(1, b[0]));
                    rd(8, v); chk("R4", "month step", v, enc(em, b[0]));
                    rd(9, v); chk("R4", "year step", v, enc(ey, b[0]));
                    rd(6, v); chk("R4", "weekday wrap", v, enc(1, b[0]));
                end
            end
        end
        load(0, 1, 59, 59, 23, 2, 28, 2, 24);
        ticks(TK / 2); rd(7, v); chk("R4", "Feb 28 leap to 29", v, 'h29);
        load(0, 1, 59, 59, 23, 2, 28, 2, 23);
        ticks(TK / 2); rd(7, v); chk("R4", "Feb 28 common to 1", v, 'h01);
        rd(8, v); chk("R4", "Feb common to March", v, 'h03);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule